// File: doc/BRIEF.md
# Bounded-Response Window Monitor

This block is a synthesizable, deterministic finite-state checker for one temporal rule: every cycle in which `trig_i` is high opens an obligation, and `rsp_i` must be high in some cycle between 2 and 5 cycles after that trigger. The checker is the subset construction of a small nondeterministic automaton. Each automaton state is one flip-flop, and each state stands for one obligation age. The next value of a state bit is the OR of the contributions from the predecessor bits that are set.

Overlapping obligations with the same age merge into the same bit. The number of flip-flops is therefore fixed, no matter how many triggers are outstanding or how long the run lasts. The monitor never counts, bounds or drops triggers.

The verdict is three-valued. The rule holds at all times, so the verdict can never become pass. It starts at ongoing and moves to fail when an obligation expires. When that happens, a one-cycle fail pulse and a fail flag are raised, and the flag stays set until reset. The monitor can sit next to a design in simulation or in emulation.

Top module: `rsp_window_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fail_pulse_o` and `fail_sticky_o` are 0 and `verdict_o` is 2'b00 (ongoing).
- R2: A trigger sampled in cycle c, followed by `rsp_i` high in any single cycle from c+2 to c+5, produces no fail.
- R3: A response that comes only at age 1 (cycle c+1) leaves the obligation from cycle c pending, so a fail follows.
- R4: If an obligation reaches age 5 (cycle c+5) and `rsp_i` is low in that cycle, `fail_pulse_o` is high for exactly the one cycle after that edge (cycle c+6). A response at age 6 is too late to prevent it.
- R5: `fail_sticky_o` goes high in the same cycle as `fail_pulse_o` and stays high until reset.
- R6: `verdict_o` is 2'b10 (fail) exactly when `fail_sticky_o` is high, and is otherwise 2'b00 (ongoing). The value 2'b01 (pass) never appears.
- R7: A single response discharges every pending obligation of age 2 to 5 at once. Triggers on every cycle are tracked without loss.
- R8: A trigger and a response in the same cycle count as age 0, so that response does not discharge the new obligation.
- R9: Reset clears all pending obligations. Triggers seen before reset cause no fail afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Opens an obligation in the cycle it is high |
| rsp_i | input | 1 | Response; discharges obligations of age 2 to 5 |
| verdict_o | output | 2 | 2'b00 ongoing, 2'b01 pass (unused), 2'b10 fail |
| fail_pulse_o | output | 1 | High for one cycle per expiry cycle |
| fail_sticky_o | output | 1 | Set on the first fail, cleared only by reset |

## Verification
The assertions assume that `trig_i` and `rsp_i` are synchronous to `clk_i` and have known values at every rising edge once reset has been released. The bench changes both inputs only on falling edges and drives them to 0 while reset is asserted, so every edge samples a settled, defined value. The assertions also assume that an expiry can only come from a trigger seen since the last reset. The bench makes this true because each scenario starts with a reset, including the one that asserts reset while obligations are still pending.

// File: rtl/rsp_mon_pkg.sv
package rsp_mon_pkg;
  typedef enum logic [1:0] {
    VERDICT_ONGOING = 2'b00,
    VERDICT_PASS    = 2'b01,
    VERDICT_FAIL    = 2'b10
  } verdict_e;
endpackage

// File: rtl/rsp_age_shift.sv
// One flop per obligation age 1..MAX_LAT; age 0 is the live trigger input.
module rsp_age_shift #(
  parameter int unsigned MIN_LAT = 2,
  parameter int unsigned MAX_LAT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic rsp_i,
  output logic expire_o
);
  logic [MAX_LAT:0] age_cur;
  logic [MAX_LAT:1] age_q, age_d;

  assign age_cur = {age_q, trig_i};

  for (genvar k = 1; k <= MAX_LAT; k++) begin : g_age
    localparam bit PREV_IN_WIN = ((k - 1) >= MIN_LAT);
    if (PREV_IN_WIN) begin : g_win
      assign age_d[k] = age_cur[k-1] & ~rsp_i;
    end else begin : g_hold
      assign age_d[k] = age_cur[k-1];
    end
  end

  // Oldest age leaves the window: unanswered means expiry.
  assign expire_o = age_q[MAX_LAT] & ~rsp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else         age_q <= age_d;
  end
endmodule

// File: rtl/rsp_fail_track.sv
module rsp_fail_track
  import rsp_mon_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     expire_i,
  output logic     fail_pulse_o,
  output logic     fail_sticky_o,
  output verdict_e verdict_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_pulse_o  <= 1'b0;
      fail_sticky_o <= 1'b0;
    end else begin
      fail_pulse_o  <= expire_i;
      fail_sticky_o <= fail_sticky_o | expire_i;
    end
  end

  // Safety rule: pass is unreachable.
  assign verdict_o = fail_sticky_o ? VERDICT_FAIL : VERDICT_ONGOING;
endmodule

// File: rtl/rsp_window_monitor.sv
module rsp_window_monitor
  import rsp_mon_pkg::*;
#(
  parameter int unsigned MIN_LAT = 2,
  parameter int unsigned MAX_LAT = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic       rsp_i,
  output logic [1:0] verdict_o,
  output logic       fail_pulse_o,
  output logic       fail_sticky_o
);
  logic     expire;
  verdict_e verdict;

  rsp_age_shift #(
    .MIN_LAT(MIN_LAT),
    .MAX_LAT(MAX_LAT)
  ) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig_i),
    .rsp_i   (rsp_i),
    .expire_o(expire)
  );

  rsp_fail_track u_fail (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .expire_i     (expire),
    .fail_pulse_o (fail_pulse_o),
    .fail_sticky_o(fail_sticky_o),
    .verdict_o    (verdict)
  );

  assign verdict_o = verdict;
endmodule

module rsp_window_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       trig_i,
  input logic       rsp_i,
  input logic [1:0] verdict_o,
  input logic       fail_pulse_o,
  input logic       fail_sticky_o
);
  logic seen_trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_trig_q <= 1'b0;
    else if (trig_i) seen_trig_q <= 1'b1;
  end

  AST_STICKY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_sticky_o |=> fail_sticky_o); // R5
  AST_PULSE_SETS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_pulse_o |-> fail_sticky_o); // R5
  AST_STICKY_NEEDS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_sticky_o) |-> fail_pulse_o); // R5
  AST_NEVER_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_o != 2'b01); // R6
  AST_VERDICT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_o == 2'b10) == fail_sticky_o); // R6
  AST_PULSE_AFTER_SILENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_pulse_o |-> !$past(rsp_i)); // R4
  AST_QUIET_NO_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_trig_q |-> !fail_pulse_o); // R9
endmodule

bind rsp_window_monitor rsp_window_monitor_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trig_i       (trig_i),
  .rsp_i        (rsp_i),
  .verdict_o    (verdict_o),
  .fail_pulse_o (fail_pulse_o),
  .fail_sticky_o(fail_sticky_o)
);

// File: tb/tb_rsp_window_monitor.sv
module tb_rsp_window_monitor;
  logic       clk_i = 1'b0;
  logic       rst_ni, trig_i, rsp_i;
  logic [1:0] verdict_o;
  logic       fail_pulse_o, fail_sticky_o;

  int n_chk = 0, n_fail = 0, cyc = 0, pulse_cnt = 0;
  int pend_q[$];
  bit exp_pulse = 0, exp_sticky = 0;

  always #2 clk_i = ~clk_i;

  rsp_window_monitor dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .rsp_i(rsp_i),
    .verdict_o(verdict_o), .fail_pulse_o(fail_pulse_o), .fail_sticky_o(fail_sticky_o)
  );

  task automatic check_bit(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic check_all(string req);
    n_chk++;
    if (verdict_o !== (exp_sticky ? 2'b10 : 2'b00)) begin
      n_fail++;
      $display("FAIL %s verdict: actual %b expected %b (cycle %0d)", req, verdict_o,
               exp_sticky ? 2'b10 : 2'b00, cyc);
    end
    check_bit(req, "pulse", fail_pulse_o, exp_pulse);
    check_bit(req, "sticky", fail_sticky_o, exp_sticky);
  endtask

  // Reference: queue of trigger timestamps, window ages 2..5.
  task automatic step(string req, bit t, bit r);
    int keep[$];
    bit f;
    f = 0;
    @(negedge clk_i);
    trig_i = t;
    rsp_i  = r;
    @(posedge clk_i);
    foreach (pend_q[i]) begin
      int age;
      age = cyc - pend_q[i];
      if (r && age >= 2 && age <= 5) begin
      end else if (age >= 5) f = 1;
      else keep.push_back(pend_q[i]);
    end
    if (t) keep.push_back(cyc);
    pend_q = keep;
    exp_pulse = f;
    exp_sticky = exp_sticky | f;
    cyc++;
    #1;
    if (fail_pulse_o === 1'b1) pulse_cnt++;
    check_all(req);
  endtask

  task automatic apply_reset(string req);
    @(negedge clk_i);
    rst_ni = 1'b0;
    trig_i = 1'b0;
    rsp_i  = 1'b0;
    pend_q.delete();
    exp_pulse = 0;
    exp_sticky = 0;
    pulse_cnt = 0;
    #1 check_all(req);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_state();
    apply_reset("R1");
    repeat (3) step("R1", 0, 0);
  endtask

  task automatic t_resp_at_age(int n, string req);
    bit late;
    late = (n < 2 || n > 5);
    apply_reset(req);
    step(req, 1, 0);
    for (int a = 1; a <= 9; a++) step(req, 0, a == n);
    check_bit(req, "sticky after window", fail_sticky_o, late);
    check_bit(req, "single pulse", pulse_cnt == (late ? 1 : 0), 1'b1);
    n_chk++;
    if (verdict_o !== (late ? 2'b10 : 2'b00)) begin
      n_fail++;
      $display("FAIL R6 verdict after window: actual %b expected %b", verdict_o,
               late ? 2'b10 : 2'b00);
    end
  endtask

  task automatic t_same_cycle();
    apply_reset("R8");
    step("R8", 1, 1);
    repeat (8) step("R8", 0, 0);
    check_bit("R8", "same-cycle response ignored", fail_sticky_o, 1'b1);
  endtask

  task automatic t_overlap();
    apply_reset("R7");
    for (int i = 0; i < 24; i++) step("R7", 1, 1);
    repeat (8) step("R7", 0, 1);
    check_bit("R7", "every-cycle responses", fail_sticky_o, 1'b0);
    apply_reset("R7");
    for (int i = 0; i < 32; i++) step("R7", i < 24, (i % 4) == 0);
    check_bit("R7", "period-4 responses", fail_sticky_o, 1'b0);
    apply_reset("R7");
    for (int i = 0; i < 32; i++) step("R7", i < 24, (i % 5) == 0);
    check_bit("R7", "period-5 responses", fail_sticky_o, 1'b1);
  endtask

  task automatic t_sticky();
    apply_reset("R5");
    step("R5", 1, 0);
    repeat (6) step("R5", 0, 0);
    for (int i = 0; i < 12; i++) step("R5", 0, i[0]);
    check_bit("R5", "sticky holds", fail_sticky_o, 1'b1);
    check_bit("R5", "pulse gone", fail_pulse_o, 1'b0);
  endtask

  task automatic t_mid_reset();
    apply_reset("R9");
    for (int i = 0; i < 4; i++) step("R9", 1, 0);
    apply_reset("R9");
    repeat (10) step("R9", 0, 0);
    check_bit("R9", "no fail after reset", fail_sticky_o, 1'b0);
  endtask

  task automatic t_random();
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    apply_reset("R7");
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R7", lfsr[0] & lfsr[4], lfsr[3] | lfsr[7]);
    end
  endtask

  initial begin
    rst_ni = 1'b0;
    trig_i = 1'b0;
    rsp_i  = 1'b0;
    t_reset_state();
    t_resp_at_age(2, "R2");
    t_resp_at_age(5, "R2");
    t_resp_at_age(1, "R3");
    t_resp_at_age(6, "R4");
    t_same_cycle();
    t_overlap();
    t_sticky();
    t_mid_reset();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule